// File: doc/BRIEF.md
# Selective Region Row Scan Driver

This block drives the row-select (gate) lines of a panel with `ROWS` rows, one row per line period. A one-cycle `line_tick_i` marks each line boundary. All inputs are sampled on a tick, and the gate outputs change only on a tick. Between ticks they hold steady.

A full programming frame begins with a start pulse on `start_i`. Row 0 fires on that line, and the pulse then walks one row per line down to the last row while `oe_i` stays high. During that frame, a high `data_i` on the tick where row n-1 is lit writes a mark for row n into that row's own memory bit. A later frame can then refresh only a band of rows. No start pulse is given. Instead, a tick with `data_i` high and `oe_i` low launches a pulse at every marked row. The pulse walks downward while `oe_i` stays high. The next tick with `oe_i` low cuts every handoff and ends the band. Rows outside the band see no pulse, so the pixels there keep their previous content.

A small controller tracks the frame mode. It has three states. IDLE means no pulse is in flight. PROG means a programming frame is running. PART means a partial band is running. The transitions are as follows:
- start: IDLE, PART or PROG goes to PROG on a tick with `start_i`.
- launch: IDLE goes to PART on a tick with `data_i` high, `oe_i` low and at least one mark stored.
- drain: PROG or PART goes back to IDLE once no gate line is high and no start is being taken.

Marks are written only in PROG.

Top module: `srsd_top`

## Requirements
- R1: After reset all gate outputs are low and no row holds a mark, so a launch tick (`data_i`=1, `oe_i`=0) lights no row.
- R2: A tick with `start_i`=1 drives row 0 (bit 0 of `gate_o`) high for that line. A tick with `start_i`=0 drives row 0 low, regardless of `oe_i` and `data_i`.
- R3: `gate_o` changes only on the clock edge where `line_tick_i` is high.
- R4: In a programming frame, a tick with `data_i`=1 and `oe_i`=1 while row n-1 is high marks row n, for n of 1 or more. Outside a programming frame no mark is written.
- R5: Marks persist across any number of partial frames. They are cleared only by reset or by a tick with `start_i`=1. That clear takes priority over a write on the same tick.
- R6: A tick with `data_i`=1 and `oe_i`=0 drives every marked row high for that line.
- R7: A tick with `oe_i`=1 drives row n high exactly when row n-1 was high, for n of 1 or more, unless row n is being launched. A lit row drops after one line.
- R8: A tick with `oe_i`=0 stops all handoffs. Rows 1 and above are then high only where a launch lights them.
- R9: A row of 1 or more never rises unless its predecessor was high or it is launched. Rows outside the band stay low for the whole partial frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick_i | input | 1 | One-cycle line boundary strobe |
| start_i | input | 1 | Frame start pulse, sampled on a tick |
| data_i | input | 1 | Region data strobe: sets marks in a programming frame, launches a band in a partial frame |
| oe_i | input | 1 | Output enable. A high level lets the pulse pass to the next row; a low level on a tick blocks the handoff |
| gate_o | output | ROWS | Gate line per row, bit n drives row n |

## Verification
The assertions assume that inputs are sampled only on ticks and that a tick lasts one clock cycle. They also assume that ticks are at least two cycles apart, so the controller drains to IDLE before the next line. The stimulus raises `line_tick_i` for exactly one cycle in a line of four cycles. It changes `start_i`, `data_i` and `oe_i` only together with that tick. Between ticks, `oe_i` rests high and the strobes rest low.

// File: rtl/srsd_pkg.sv
package srsd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROG = 2'd1,
        ST_PART = 2'd2
    } scan_state_t;
endpackage

// File: rtl/srsd_stage.sv
module srsd_stage #(
    parameter bit HAS_MARK = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic chain_in,
    input  logic pass_en,
    input  logic launch,
    input  logic mark_wr,
    input  logic mark_clr,
    output logic gate_o,
    output logic mark_o
);
    logic gate_q;
    logic gate_d;

    generate
        if (HAS_MARK) begin : g_mark
            logic mark_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mark_q <= 1'b0;
                end else if (mark_clr) begin
                    mark_q <= 1'b0;
                end else if (mark_wr && chain_in) begin
                    mark_q <= 1'b1;
                end
            end
            assign mark_o = mark_q;
            always_comb gate_d = (chain_in && pass_en) || (mark_q && launch);
        end else begin : g_plain
            assign mark_o = 1'b0;
            always_comb gate_d = chain_in;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (tick) begin
            gate_q <= gate_d;
        end
    end

    assign gate_o = gate_q;
endmodule

// File: rtl/srsd_ctrl.sv
module srsd_ctrl
    import srsd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        start,
    input  logic        data,
    input  logic        oe,
    input  logic        any_gate,
    input  logic        any_mark,
    output logic        mark_wr,
    output logic        mark_clr,
    output logic        launch,
    output scan_state_t state_o
);
    scan_state_t state_q;
    scan_state_t state_d;
    logic        take_start;
    logic        take_launch;

    always_comb begin
        take_start  = tick && start;
        take_launch = tick && data && !oe;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_start) begin
                    state_d = ST_PROG;
                end else if (take_launch && any_mark) begin
                    state_d = ST_PART;
                end
            end
            ST_PROG: begin
                if (!take_start && !any_gate) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PART: begin
                if (take_start) begin
                    state_d = ST_PROG;
                end else if (!any_gate && !take_launch) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        mark_clr = take_start;
        mark_wr  = 1'b0;
        launch   = take_launch;
        unique case (state_q)
            ST_PROG: mark_wr = tick && data && oe;
            ST_IDLE, ST_PART: mark_wr = 1'b0;
            default: mark_wr = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/srsd_top.sv
module srsd_top
    import srsd_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_tick_i,
    input  logic            start_i,
    input  logic            data_i,
    input  logic            oe_i,
    output logic [ROWS-1:0] gate_o
);
    localparam int LAST = ROWS - 1;

    logic [ROWS-1:0] gate_q;
    logic [ROWS-1:0] mark_q;
    logic            mark_wr;
    logic            mark_clr;
    logic            launch;
    scan_state_t     state_q;

    srsd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (line_tick_i),
        .start    (start_i),
        .data     (data_i),
        .oe       (oe_i),
        .any_gate (|gate_q),
        .any_mark (|mark_q),
        .mark_wr  (mark_wr),
        .mark_clr (mark_clr),
        .launch   (launch),
        .state_o  (state_q)
    );

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            if (r == 0) begin : g_head
                srsd_stage #(.HAS_MARK(1'b0)) u_stage (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .tick     (line_tick_i),
                    .chain_in (start_i),
                    .pass_en  (1'b1),
                    .launch   (1'b0),
                    .mark_wr  (1'b0),
                    .mark_clr (1'b0),
                    .gate_o   (gate_q[r]),
                    .mark_o   (mark_q[r])
                );
            end else begin : g_body
                srsd_stage #(.HAS_MARK(1'b1)) u_stage (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .tick     (line_tick_i),
                    .chain_in (gate_q[r-1]),
                    .pass_en  (oe_i),
                    .launch   (launch),
                    .mark_wr  (mark_wr),
                    .mark_clr (mark_clr),
                    .gate_o   (gate_q[r]),
                    .mark_o   (mark_q[r])
                );
            end
        end
    endgenerate

    assign gate_o = gate_q;

    logic unused_last;
    assign unused_last = gate_q[LAST] & 1'b0;
endmodule

// File: rtl/srsd_checker.sv
module srsd_checker
    import srsd_pkg::*;
#(
    parameter int ROWS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            start,
    input logic            data,
    input logic            oe,
    input logic [ROWS-1:0] gate,
    input logic [ROWS-1:0] mark,
    input scan_state_t     state
);
    assert_row0_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (gate[0] == $past(start)));

    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(gate));

    assert_mark_only_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PROG) |=> ((mark & ~$past(mark)) == '0));

    assert_mark_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && start) |=> (($past(mark) & ~mark) == '0));

    assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && data && !oe) |=> ((gate & $past(mark)) == $past(mark)));

    assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !oe && !data) |=> (gate[ROWS-1:1] == '0));

    assert_no_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(data && !oe)) |=>
            ((gate[ROWS-1:1] & ~$past(gate[ROWS-2:0])) == '0));

    generate
        for (genvar r = 1; r < ROWS; r++) begin : g_hand
            assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && oe && gate[r-1]) |=> gate[r]);
        end
    endgenerate
endmodule

bind srsd_top srsd_checker #(.ROWS(ROWS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (line_tick_i),
    .start (start_i),
    .data  (data_i),
    .oe    (oe_i),
    .gate  (gate_q),
    .mark  (mark_q),
    .state (state_q)
);

// File: tb/srsd_top_test.sv
module srsd_top_test;
    localparam int ROWS = 16;
    localparam int WATCHDOG_CYC = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            line_tick_i = 1'b0;
    logic            start_i = 1'b0;
    logic            data_i = 1'b0;
    logic            oe_i = 1'b1;
    logic [ROWS-1:0] gate_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [ROWS-1:0] m_gate = '0;
    logic [ROWS-1:0] m_mark = '0;
    bit              m_prog = 1'b0;

    srsd_top #(.ROWS(ROWS)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_tick_i (line_tick_i),
        .start_i     (start_i),
        .data_i      (data_i),
        .oe_i        (oe_i),
        .gate_o      (gate_o)
    );

    always #5 clk = ~clk;

    function automatic logic [ROWS-1:0] exp_gate(logic [ROWS-1:0] g, logic [ROWS-1:0] mk,
                                                 bit st, bit d, bit o);
        logic [ROWS-1:0] n;
        n[0] = st;
        for (int r = 1; r < ROWS; r++) begin
            n[r] = (g[r-1] && o) || (mk[r] && d && !o);
        end
        return n;
    endfunction

    function automatic logic [ROWS-1:0] exp_mark(logic [ROWS-1:0] g, logic [ROWS-1:0] mk,
                                                 bit prog, bit st, bit d, bit o);
        logic [ROWS-1:0] n;
        if (st) return '0;
        n = mk;
        if (prog && d && o) begin
            for (int r = 1; r < ROWS; r++) begin
                if (g[r-1]) n[r] = 1'b1;
            end
        end
        return n;
    endfunction

    task automatic check(string tag, logic [ROWS-1:0] act, logic [ROWS-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: gate_o=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic line(bit st, bit d, bit o, string tag);
        logic [ROWS-1:0] ng;
        @(negedge clk);
        line_tick_i = 1'b1;
        start_i = st;
        data_i = d;
        oe_i = o;
        ng = exp_gate(m_gate, m_mark, st, d, o);
        m_mark = exp_mark(m_gate, m_mark, m_prog, st, d, o);
        if (st) m_prog = 1'b1;
        else if (ng == '0) m_prog = 1'b0;
        m_gate = ng;
        @(negedge clk);
        line_tick_i = 1'b0;
        start_i = 1'b0;
        data_i = 1'b0;
        oe_i = 1'b1;
        check(tag, gate_o, m_gate);
        @(negedge clk);
        @(negedge clk);
        check("R3 hold between ticks", gate_o, m_gate);
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 reset gates low", gate_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", gate_o, '0);
        line(1'b0, 1'b1, 1'b0, "R1 launch with empty marks");

        // programming frame: mark rows 5 and 11
        line(1'b1, 1'b0, 1'b1, "R2 start lights row0");
        for (int r = 1; r < ROWS; r++) begin
            line(1'b0, (r == 5) || (r == 11), 1'b1, "R2 R4 full scan step");
            check("R7 single lit row", gate_o, ROWS'(1) << r);
        end
        line(1'b0, 1'b0, 1'b1, "R2 scan leaves last row");
        check("R2 all low after frame", gate_o, '0);

        // partial frame: launch then stop after two handoffs
        line(1'b0, 1'b1, 1'b0, "R6 launch marked rows");
        check("R6 rows 5 and 11", gate_o, (ROWS'(1) << 5) | (ROWS'(1) << 11));
        line(1'b0, 1'b0, 1'b1, "R7 band handoff");
        line(1'b0, 1'b0, 1'b1, "R7 band handoff");
        check("R7 rows 7 and 13", gate_o, (ROWS'(1) << 7) | (ROWS'(1) << 13));
        line(1'b0, 1'b0, 1'b0, "R8 stop pulse");
        check("R8 all low after stop", gate_o, '0);
        for (int k = 0; k < 4; k++) line(1'b0, 1'b0, 1'b1, "R9 outside band quiet");

        // marks retained into a second partial frame
        line(1'b0, 1'b1, 1'b0, "R5 marks retained");
        check("R5 relaunch rows 5 and 11", gate_o, (ROWS'(1) << 5) | (ROWS'(1) << 11));
        for (int k = 0; k < ROWS; k++) line(1'b0, 1'b0, 1'b1, "R7 run off end");
        line(1'b0, 1'b0, 1'b1, "R9 quiet after band");

        // data strobe in a partial frame writes no mark
        line(1'b0, 1'b1, 1'b0, "R6 launch again");
        line(1'b0, 1'b1, 1'b1, "R4 strobe outside programming");
        line(1'b0, 1'b0, 1'b0, "R8 stop");
        line(1'b0, 1'b1, 1'b0, "R4 no new mark");
        check("R4 only rows 5 and 11", gate_o, (ROWS'(1) << 5) | (ROWS'(1) << 11));
        line(1'b0, 1'b0, 1'b0, "R8 stop");

        // start clears marks
        line(1'b1, 1'b0, 1'b1, "R5 start clears marks");
        for (int k = 0; k < ROWS; k++) line(1'b0, 1'b0, 1'b1, "R2 clean scan");
        line(1'b0, 1'b1, 1'b0, "R5 launch after clear");
        check("R5 cleared marks light nothing", gate_o, '0);

        // constrained random lines
        for (int k = 0; k < 800; k++) begin
            bit st, d, o;
            st = ($urandom % 24) == 0;
            d  = ($urandom % 4) == 0;
            o  = ($urandom % 6) != 0;
            line(st, d, o, "R2 R4 R6 R7 R8 R9 random line");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule